// File: doc/BRIEF.md
# Host Window Page Remapper

This block translates host memory accesses that fall in the 128K window from A0000h to BFFFFh into addresses in a display memory of up to 1M bytes. Three byte-wide registers control it. The control register holds an enable bit, a page size bit and a page count bit. The other two registers hold base offsets, called offset A and offset B.

The window is split into four 32K quadrants. The control bits decide which quadrants are translated and which offset register each one uses. For a translated access, the upper eight bits of the display address are the sum, modulo 256, of the chosen offset and the page-relative 4K block number of the host address. Each offset therefore places a page on any 4K boundary of display memory. Every other access passes through unchanged.

Registers are loaded through a simple write port. The translation itself is purely combinational from the host address and the current register contents.

Top module: `page_remap`

## Requirements
- R1: When control bit 0 (enable) is 0, mem_addr equals host_addr for every host address.
- R2: mem_addr[11:0] always equals host_addr[11:0].
- R3: With control bit 1 = 0 (32K pages), a translated access gives mem_addr[19:12] = offset + host_addr[14:12].
- R4: With control bit 1 = 1 (64K pages), a translated access gives mem_addr[19:12] = offset + host_addr[15:12].
- R5: The 8-bit sum wraps modulo 256. Overflow is discarded and does not affect any other bit.
- R6: With control bits [2:1] = 00, only A0000h–A7FFFh is translated, through offset A.
- R7: With control bits [2:1] = 01, A0000h–AFFFFh is translated through offset A.
- R8: With control bits [2:1] = 10, A0000h–A7FFFh uses offset A and A8000h–AFFFFh uses offset B.
- R9: With control bits [2:1] = 11, A0000h–AFFFFh uses offset A and B0000h–BFFFFh uses offset B.
- R10: Host addresses outside A0000h–BFFFFh, and window quadrants not named for the current setting, pass through unchanged.
- R11: The write port uses wr_sel 0 for control, 1 for offset A and 2 for offset B. While ctl_lock is 1, a control write is ignored, but offset writes still take effect.
- R12: After reset all three registers are 0, so every address passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 offset A, 2 offset B |
| wr_data | input | 8 | Write data (control uses bits 2:0) |
| ctl_lock | input | 1 | Write protect for the control register |
| host_addr | input | 20 | Host address |
| mem_addr | output | 20 | Translated display memory address |

## Verification
The checker asserts on every cycle that the low twelve bits are never altered. It also asserts that the output equals the input when translation is disabled, when the address is outside the window, or when the quadrant is excluded by the control setting. It further checks that a locked control write leaves the control state unchanged. The arithmetic of the translated bits cannot be checked that way: the per-mode quadrant-to-offset choice, the 3-bit versus 4-bit page field, and the modulo-256 wrap are shown only by the bench's sweeps. Those sweeps cover every control value across the whole window and its edges, with offsets chosen so that the sum overflows.

// File: rtl/page_remap.sv
module page_remap #(
  parameter int AW = 20,
  parameter int OW = 8,
  parameter int PG = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [OW-1:0] wr_data,
  input  logic          ctl_lock,
  input  logic [AW-1:0] host_addr,
  output logic [AW-1:0] mem_addr
);
  localparam logic [2:0] WIN_TAG = 3'b101;

  logic [2:0]    ctl_q;
  logic [OW-1:0] ofs_a_q, ofs_b_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      ofs_a_q <= '0;
      ofs_b_q <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        2'd0: if (!ctl_lock) ctl_q <= wr_data[2:0];
        2'd1: ofs_a_q <= wr_data;
        2'd2: ofs_b_q <= wr_data;
        default: ;
      endcase
    end
  end

  wire       in_win = host_addr[AW-1:AW-3] == WIN_TAG;
  wire [1:0] quad   = host_addr[AW-4:AW-5];
  wire       big    = ctl_q[1];
  wire       dual   = ctl_q[2];

  wire use_a = (quad == 2'd0) || (big && quad == 2'd1);
  wire use_b = dual && (big ? quad[1] : (quad == 2'd1));
  wire hit   = ctl_q[0] && in_win && (use_a || use_b);

  logic [OW-1:0] page_blk, sum;
  assign page_blk = big ? OW'(host_addr[PG+3:PG]) : OW'(host_addr[PG+2:PG]);
  assign sum      = (use_b ? ofs_b_q : ofs_a_q) + page_blk;

  assign mem_addr = hit ? {sum, host_addr[PG-1:0]} : host_addr;
endmodule

// File: rtl/page_remap_chk.sv
module page_remap_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [1:0]  wr_sel,
  input logic        ctl_lock,
  input logic [2:0]  ctl,
  input logic [19:0] host_addr,
  input logic [19:0] mem_addr
);
  wire in_win = host_addr[19:17] == 3'b101;

  // R2
  low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_addr[11:0] == host_addr[11:0]);

  // R1
  disabled_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl[0] |-> mem_addr == host_addr);

  // R10
  outside_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_win |-> mem_addr == host_addr);

  // R6
  upper_half_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_win && host_addr[16] && ctl[2:1] != 2'b11) |-> mem_addr == host_addr);

  // R11
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0 && ctl_lock) |=> $stable(ctl));
endmodule

bind page_remap page_remap_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
  .ctl_lock(ctl_lock), .ctl(ctl_q), .host_addr(host_addr), .mem_addr(mem_addr)
);

// File: tb/sim_page_remap.sv
module sim_page_remap;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [1:0]  wr_sel = 0;
  logic [7:0]  wr_data = 0;
  logic        ctl_lock = 0;
  logic [19:0] host_addr = 0;
  logic [19:0] mem_addr;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  page_remap u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .ctl_lock(ctl_lock), .host_addr(host_addr), .mem_addr(mem_addr));

  function automatic int expect_addr(int h, int c, int a, int b);
    int q, sel, psz, blk;
    if ((c & 1) == 0 || h < 'hA0000 || h >= 'hC0000) return h;
    q = (h - 'hA0000) / 'h8000;
    sel = 0;
    case ((c >> 1) & 3)
      0: if (q == 0) sel = 1;
      1: if (q <= 1) sel = 1;
      2: if (q == 0) sel = 1; else if (q == 1) sel = 2;
      default: if (q <= 1) sel = 1; else sel = 2;
    endcase
    if (sel == 0) return h;
    psz = ((c >> 1) & 1) ? 'h10000 : 'h8000;
    blk = (h % psz) / 4096;
    return ((((sel == 1 ? a : b) + blk) % 256) * 4096) + (h % 4096);
  endfunction

  task automatic wr(input int sel, input int d);
    @(negedge clk);
    wr_en = 1; wr_sel = 2'(sel); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic probe(input int h, input int exp_v, input string req);
    @(negedge clk);
    host_addr = 20'(h);
    #2;
    checks++;
    if (mem_addr !== 20'(exp_v)) begin
      errors++;
      $display("FAIL %s host=%h got=%h exp=%h", req, h, mem_addr, 20'(exp_v));
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R12: reset state passes through
    probe('hA3456, 'hA3456, "R12");
    probe('hBFFFF, 'hBFFFF, "R12");
    // R3..R10: sweep all control values across the window with wrapping offsets
    for (int c = 0; c < 8; c++) begin
      wr(0, c);
      wr(1, 'hF3);
      wr(2, 'h5C);
      for (int h = 'h9E000; h < 'hC2000; h += 'h1000) begin
        int hh;
        string tag;
        hh = h + ((h / 'h1000) * 'h135) % 'h1000;
        tag = (c & 1) == 0 ? "R1" : c == 1 ? "R6_R3_R5" : c == 3 ? "R7_R4_R5" :
              c == 5 ? "R8_R3_R10" : "R9_R4_R2";
        probe(hh, expect_addr(hh, c, 'hF3, 'h5C), tag);
      end
    end
    // R11: locked control write ignored, offset writes still land
    wr(0, 7);
    wr(1, 'h10);
    ctl_lock = 1;
    wr(0, 0);
    probe('hB2345, expect_addr('hB2345, 7, 'h10, 'h5C), "R11");
    wr(1, 'h20);
    probe('hA5678, expect_addr('hA5678, 7, 'h20, 'h5C), "R11");
    ctl_lock = 0;
    wr(0, 0);
    probe('hA5678, 'hA5678, "R11");
    // R5: maximum wrap
    wr(0, 3);
    wr(1, 'hFF);
    probe('hAFABC, 'h0EABC, "R5");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule